// File: doc/BRIEF.md
# Virtual-Channel Input Port Controller

This block runs one input port of an on-chip network router that carries several virtual channels. Arriving flits name their channel and are stored in that channel's own small buffer. Each channel has its own controller. The controller resolves the output port and the downstream virtual channel once, for the head flit of a packet. The body and tail flits that follow reuse that result. Because every channel keeps its own buffer and state, a packet that is stalled holds only its own channel. The other channels on the same port keep moving.

Every channel goes through four named states:
- IDLE: no packet is open. It moves to ROUTE when a head flit reaches the front of the buffer.
- ROUTE: lasts exactly one cycle. The route stub is evaluated on the head payload and the result is stored. The channel then moves to WAIT.
- WAIT: the channel asks the external virtual-channel allocator for a downstream channel on the stored port, once per cycle, until a grant arrives. The grant stores the output channel and moves it to ACTIVE.
- ACTIVE: the channel asks the external switch allocator for the crossbar while its buffer holds flits. It dequeues a flit in a cycle that has both a switch grant and a downstream credit. The departure of a tail or single-flit packet moves it back to IDLE.

The allocators, the crossbar and the credit return to upstream sit outside the block.

Top module: `vcip_input_port`

## Requirements
- R1: After reset every channel is in IDLE with an empty buffer: va_req, sa_req and out_valid are all zero.
- R2: A flit with in_valid high is stored in the buffer of channel in_vc. The flits of one channel leave in the order they arrived, and all DEPTH entries of a buffer can be filled and drained.
- R3: The route is computed once per packet. Two cycles after a head flit is written to an empty IDLE channel, the port chosen for that head shows on va_port. Every later flit of the packet leaves on that same port, whatever its own payload holds. A new packet on the same channel is routed again.
- R4: A channel in WAIT keeps va_req high in every cycle until va_gnt for that channel is sampled high. It issues no switch request before that.
- R5: In the cycle after a virtual-channel grant, the channel requests the switch (sa_req) for as long as its buffer holds flits. Every departing flit carries on out_ovc the downstream channel given by va_gnt_ovc at grant time.
- R6: A flit departs (out_valid high) only from an ACTIVE channel, and only in a cycle where its sa_gnt and dn_credit bits are both high. sa_gnt carries at most one bit. With no credit, or when the channel is not ACTIVE, nothing departs and the buffer is left unchanged.
- R7: Flit type encoding is 2'b01 head, 2'b00 body, 2'b10 tail and 2'b11 head+tail. Once a tail or head+tail flit departs, the channel is back in IDLE and drops both requests.
- R8: A channel waiting for a grant does not delay another channel of the same port from routing, being granted and sending its flits.
- R9: The route stub takes the low PORT_W bits of the payload as the output port. When that value is NUM_PORTS or more, NUM_PORTS is subtracted from it.
- R10: Writing into a full channel buffer is a protocol error. The upstream side must never do it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_kind | input | 2 | Incoming flit type |
| in_vc | input | VC_W | Channel the incoming flit belongs to |
| in_payload | input | DATA_W | Incoming flit payload |
| va_req | output | NUM_VC | Per-channel request for a downstream channel |
| va_port | output | NUM_VC*PORT_W | Output port each channel requests on |
| va_gnt | input | NUM_VC | Per-channel downstream-channel grant |
| va_gnt_ovc | input | NUM_VC*OVC_W | Granted downstream channel, per input channel |
| sa_req | output | NUM_VC | Per-channel switch request |
| sa_port | output | NUM_VC*PORT_W | Output port for each switch request |
| sa_gnt | input | NUM_VC | Switch grant, at most one bit set |
| dn_credit | input | NUM_VC | Downstream buffer space available, per input channel |
| out_valid | output | 1 | A flit departs this cycle |
| out_kind | output | 2 | Departing flit type |
| out_payload | output | DATA_W | Departing flit payload |
| out_port | output | PORT_W | Output port of the departing flit |
| out_ovc | output | OVC_W | Downstream channel of the departing flit |
| out_ivc | output | VC_W | Input channel the flit leaves from |

## Verification
The main path is first run with a three-flit packet on a single channel. The body flit's payload points to a different port than the head's, which separates a route that is inherited from one computed again for each flit. Grants that are withheld and switch grants with no credit show whether WAIT and ACTIVE hold their ground without losing flits. A second pattern opens two single-flit packets on separate channels and grants only one of them, which tests that the channels stay independent. A fresh head on a channel that was just freed tests re-routing. A full four-flit burst with one cycle of missing credit tests buffer depth and ordering.

// File: rtl/vcip_pkg.sv
package vcip_pkg;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ROUTE,
        CH_WAIT,
        CH_ACTIVE
    } ch_state_e;

    function automatic logic kind_opens(input logic [1:0] k);
        return k[0];
    endfunction

    function automatic logic kind_closes(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/vcip_flit_fifo.sv
module vcip_flit_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] front,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign front   = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/vcip_route_stub.sv
module vcip_route_stub #(
    parameter int DATA_W    = 16,
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic [DATA_W-1:0] payload,
    output logic [PORT_W-1:0] port
);
    logic [PORT_W-1:0] raw;
    assign raw = payload[PORT_W-1:0];

    generate
        if (NUM_PORTS == (1 << PORT_W)) begin : g_exact
            assign port = raw;
        end else begin : g_wrap
            always_comb begin
                if ({1'b0, raw} >= (PORT_W+1)'(NUM_PORTS))
                    port = PORT_W'({1'b0, raw} - (PORT_W+1)'(NUM_PORTS));
                else
                    port = raw;
            end
        end
    endgenerate
endmodule

// File: rtl/vcip_vc_ctrl.sv
module vcip_vc_ctrl
    import vcip_pkg::*;
#(
    parameter int PORT_W = 2,
    parameter int OVC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              front_valid,
    input  logic [1:0]        front_kind,
    input  logic [PORT_W-1:0] route_port,
    input  logic              va_gnt,
    input  logic [OVC_W-1:0]  va_gnt_ovc,
    input  logic              sa_gnt,
    input  logic              dn_credit,
    output logic              va_req,
    output logic              sa_req,
    output logic              pop,
    output logic [PORT_W-1:0] req_port,
    output logic [OVC_W-1:0]  held_ovc,
    output ch_state_e         state
);
    ch_state_e nxt;

    // state register with the per-packet route and channel holders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CH_IDLE;
            req_port <= '0;
            held_ovc <= '0;
        end else begin
            state <= nxt;
            if (state == CH_ROUTE)
                req_port <= route_port;
            if (state == CH_WAIT && va_gnt)
                held_ovc <= va_gnt_ovc;
        end
    end

    // outputs
    always_comb begin
        va_req = 1'b0;
        sa_req = 1'b0;
        unique case (state)
            CH_IDLE:   ;
            CH_ROUTE:  ;
            CH_WAIT:   va_req = 1'b1;
            CH_ACTIVE: sa_req = front_valid;
        endcase
        pop = sa_req && sa_gnt && dn_credit;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE:   if (front_valid && kind_opens(front_kind)) nxt = CH_ROUTE;
            CH_ROUTE:  nxt = CH_WAIT;
            CH_WAIT:   if (va_gnt) nxt = CH_ACTIVE;
            CH_ACTIVE: if (pop && kind_closes(front_kind)) nxt = CH_IDLE;
        endcase
    end
endmodule

// File: rtl/vcip_input_port.sv
module vcip_input_port
    import vcip_pkg::*;
#(
    parameter int NUM_VC    = 4,
    parameter int BUF_DEPTH = 4,
    parameter int DATA_W    = 16,
    parameter int NUM_PORTS = 4,
    parameter int NUM_OVC   = 4,
    localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int OVC_W    = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_kind,
    input  logic [VC_W-1:0]          in_vc,
    input  logic [DATA_W-1:0]        in_payload,
    output logic [NUM_VC-1:0]        va_req,
    output logic [NUM_VC*PORT_W-1:0] va_port,
    input  logic [NUM_VC-1:0]        va_gnt,
    input  logic [NUM_VC*OVC_W-1:0]  va_gnt_ovc,
    output logic [NUM_VC-1:0]        sa_req,
    output logic [NUM_VC*PORT_W-1:0] sa_port,
    input  logic [NUM_VC-1:0]        sa_gnt,
    input  logic [NUM_VC-1:0]        dn_credit,
    output logic                     out_valid,
    output logic [1:0]               out_kind,
    output logic [DATA_W-1:0]        out_payload,
    output logic [PORT_W-1:0]        out_port,
    output logic [OVC_W-1:0]         out_ovc,
    output logic [VC_W-1:0]          out_ivc
);
    localparam int ENTRY_W = DATA_W + 2;

    logic [NUM_VC-1:0] buf_full;
    logic [NUM_VC-1:0] buf_empty;
    logic [NUM_VC-1:0] pop_vec;
    logic [1:0]        fr_kind [NUM_VC];
    logic [DATA_W-1:0] fr_pay  [NUM_VC];
    logic [PORT_W-1:0] ch_port [NUM_VC];
    logic [OVC_W-1:0]  ch_ovc  [NUM_VC];

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
            logic [ENTRY_W-1:0] front;
            logic [PORT_W-1:0]  routed;
            ch_state_e          st;

            vcip_flit_fifo #(.WIDTH(ENTRY_W), .DEPTH(BUF_DEPTH)) u_buf (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (in_valid && (in_vc == VC_W'(v))),
                .push_data ({in_kind, in_payload}),
                .pop       (pop_vec[v]),
                .front     (front),
                .empty     (buf_empty[v]),
                .full      (buf_full[v])
            );

            assign fr_kind[v] = front[ENTRY_W-1 -: 2];
            assign fr_pay[v]  = front[DATA_W-1:0];

            vcip_route_stub #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_route (
                .payload (fr_pay[v]),
                .port    (routed)
            );

            vcip_vc_ctrl #(.PORT_W(PORT_W), .OVC_W(OVC_W)) u_ctrl (
                .clk         (clk),
                .rst_n       (rst_n),
                .front_valid (!buf_empty[v]),
                .front_kind  (fr_kind[v]),
                .route_port  (routed),
                .va_gnt      (va_gnt[v]),
                .va_gnt_ovc  (va_gnt_ovc[v*OVC_W +: OVC_W]),
                .sa_gnt      (sa_gnt[v]),
                .dn_credit   (dn_credit[v]),
                .va_req      (va_req[v]),
                .sa_req      (sa_req[v]),
                .pop         (pop_vec[v]),
                .req_port    (ch_port[v]),
                .held_ovc    (ch_ovc[v]),
                .state       (st)
            );

            assign va_port[v*PORT_W +: PORT_W] = ch_port[v];
            assign sa_port[v*PORT_W +: PORT_W] = ch_port[v];
        end
    endgenerate

    always_comb begin
        out_valid   = |pop_vec;
        out_kind    = '0;
        out_payload = '0;
        out_port    = '0;
        out_ovc     = '0;
        out_ivc     = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (pop_vec[v]) begin
                out_kind    = fr_kind[v];
                out_payload = fr_pay[v];
                out_port    = ch_port[v];
                out_ovc     = ch_ovc[v];
                out_ivc     = VC_W'(v);
            end
        end
    end
endmodule

// File: rtl/vcip_input_port_chk.sv
module vcip_input_port_chk #(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2,
    parameter int PORT_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [VC_W-1:0]          in_vc,
    input logic [NUM_VC-1:0]        buf_full,
    input logic [NUM_VC-1:0]        va_req,
    input logic [NUM_VC-1:0]        va_gnt,
    input logic [NUM_VC-1:0]        sa_req,
    input logic [NUM_VC*PORT_W-1:0] sa_port,
    input logic [NUM_VC-1:0]        sa_gnt,
    input logic [NUM_VC-1:0]        dn_credit,
    input logic [NUM_VC-1:0]        pop_vec,
    input logic                     out_valid,
    input logic [1:0]               out_kind
);
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !buf_full[in_vc]);

    // R6
    sa_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sa_gnt));

    // R6
    depart_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> |(sa_req & sa_gnt & dn_credit));

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_c
            // R4
            va_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                va_req[v] && !va_gnt[v] |=> va_req[v] && !sa_req[v]);

            // R5
            va_to_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
                va_req[v] && va_gnt[v] |=> sa_req[v]);

            // R3
            port_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sa_req[v] && $past(sa_req[v]) |-> $stable(sa_port[v*PORT_W +: PORT_W]));

            // R7
            tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pop_vec[v] && out_kind[1] |=> !sa_req[v] && !va_req[v]);
        end
    endgenerate
endmodule

bind vcip_input_port vcip_input_port_chk #(
    .NUM_VC (NUM_VC),
    .VC_W   (VC_W),
    .PORT_W (PORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vc     (in_vc),
    .buf_full  (buf_full),
    .va_req    (va_req),
    .va_gnt    (va_gnt),
    .sa_req    (sa_req),
    .sa_port   (sa_port),
    .sa_gnt    (sa_gnt),
    .dn_credit (dn_credit),
    .pop_vec   (pop_vec),
    .out_valid (out_valid),
    .out_kind  (out_kind)
);

// File: tb/tb_vcip_input_port.sv
module tb_vcip_input_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_kind;
    logic [1:0]  in_vc;
    logic [15:0] in_payload;
    logic [3:0]  va_req;
    logic [7:0]  va_port;
    logic [3:0]  va_gnt;
    logic [7:0]  va_gnt_ovc;
    logic [3:0]  sa_req;
    logic [7:0]  sa_port;
    logic [3:0]  sa_gnt;
    logic [3:0]  dn_credit;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [15:0] out_payload;
    logic [1:0]  out_port;
    logic [1:0]  out_ovc;
    logic [1:0]  out_ivc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcip_input_port dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_vc(in_vc), .in_payload(in_payload), .va_req(va_req), .va_port(va_port),
        .va_gnt(va_gnt), .va_gnt_ovc(va_gnt_ovc), .sa_req(sa_req), .sa_port(sa_port),
        .sa_gnt(sa_gnt), .dn_credit(dn_credit), .out_valid(out_valid),
        .out_kind(out_kind), .out_payload(out_payload), .out_port(out_port),
        .out_ovc(out_ovc), .out_ivc(out_ivc)
    );

    typedef struct packed {
        logic        wv;
        logic [1:0]  wk;
        logic [1:0]  wvc;
        logic [15:0] wp;
        logic [3:0]  vg;
        logic [1:0]  vo;
        logic [3:0]  sg;
        logic [3:0]  cr;
        logic [3:0]  xva;
        logic [1:0]  xvp;
        logic [3:0]  xsa;
        logic        xov;
        logic [15:0] xp;
        logic [1:0]  xport;
        logic [1:0]  xovc;
        logic [1:0]  xivc;
    } row_t;

    // one three-flit packet on channel 1; body payload points at port 0 to expose re-routing
    localparam row_t TBL [10] = '{
        '{1'b1, 2'b01, 2'd1, 16'h0012, 4'b0000, 2'd0, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0},
        '{1'b1, 2'b00, 2'd1, 16'h0034, 4'b0000, 2'd0, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0},
        '{1'b1, 2'b10, 2'd1, 16'h0056, 4'b0000, 2'd0, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0000, 2'd0, 4'b0000, 4'b0000, 4'b0010, 2'd2, 4'b0000, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0010, 2'd3, 4'b0000, 4'b0000, 4'b0010, 2'd2, 4'b0000, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0000, 2'd0, 4'b0010, 4'b0000, 4'b0000, 2'd0, 4'b0010, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0000, 2'd0, 4'b0010, 4'b0010, 4'b0000, 2'd0, 4'b0010, 1'b1, 16'h0012, 2'd2, 2'd3, 2'd1},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0000, 2'd0, 4'b0010, 4'b0010, 4'b0000, 2'd0, 4'b0010, 1'b1, 16'h0034, 2'd2, 2'd3, 2'd1},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0000, 2'd0, 4'b0010, 4'b0010, 4'b0000, 2'd0, 4'b0010, 1'b1, 16'h0056, 2'd2, 2'd3, 2'd1},
        '{1'b0, 2'b00, 2'd0, 16'h0000, 4'b0000, 2'd0, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 2'd0, 2'd0, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_kind = 2'b00; in_vc = 2'd0; in_payload = '0;
        va_gnt = '0; va_gnt_ovc = '0; sa_gnt = '0; dn_credit = '0;
    endtask

    task automatic put(input logic [1:0] vc, input logic [1:0] k, input logic [15:0] p);
        in_valid = 1'b1; in_vc = vc; in_kind = k; in_payload = p;
        tick();
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [3:0] g, input string tag, input logic [15:0] p,
                        input logic [1:0] port, input logic [1:0] ovc, input logic [1:0] ivc);
        sa_gnt = g; dn_credit = 4'b1111;
        #1;
        chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
        chk({tag, " out_payload"}, 32'(out_payload), 32'(p));
        chk({tag, " out_port"}, 32'(out_port), 32'(port));
        chk({tag, " out_ovc"}, 32'(out_ovc), 32'(ovc));
        chk({tag, " out_ivc"}, 32'(out_ivc), 32'(ivc));
        tick();
        sa_gnt = '0; dn_credit = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 va_req after reset", 32'(va_req), 32'd0);
        chk("R1 sa_req after reset", 32'(sa_req), 32'd0);
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);

        // table walk
        for (int i = 0; i < 10; i++) begin
            in_valid = TBL[i].wv; in_kind = TBL[i].wk; in_vc = TBL[i].wvc; in_payload = TBL[i].wp;
            va_gnt = TBL[i].vg; va_gnt_ovc = {4{TBL[i].vo}};
            sa_gnt = TBL[i].sg; dn_credit = TBL[i].cr;
            #1;
            chk($sformatf("R4 va_req row %0d", i), 32'(va_req), 32'(TBL[i].xva));
            chk($sformatf("R5 sa_req row %0d", i), 32'(sa_req), 32'(TBL[i].xsa));
            chk($sformatf("R6 out_valid row %0d", i), 32'(out_valid), 32'(TBL[i].xov));
            if (TBL[i].xva != 4'b0000)
                chk($sformatf("R3 va_port row %0d", i), 32'(va_port[3:2]), 32'(TBL[i].xvp));
            if (TBL[i].xov) begin
                chk($sformatf("R2 out_payload row %0d", i), 32'(out_payload), 32'(TBL[i].xp));
                chk($sformatf("R3 out_port row %0d", i), 32'(out_port), 32'(TBL[i].xport));
                chk($sformatf("R5 out_ovc row %0d", i), 32'(out_ovc), 32'(TBL[i].xovc));
                chk($sformatf("R2 out_ivc row %0d", i), 32'(out_ivc), 32'(TBL[i].xivc));
            end
            tick();
        end
        idle_in();

        // R8: two single-flit packets, only channel 2 granted
        put(2'd0, 2'b11, 16'h0001);
        put(2'd2, 2'b11, 16'h0003);
        tick();
        tick();
        #1;
        chk("R4 both channels waiting", 32'(va_req), 32'b0101);
        chk("R9 route of channel 2", 32'(va_port[5:4]), 32'd3);
        chk("R9 route of channel 0", 32'(va_port[1:0]), 32'd1);
        va_gnt = 4'b0100; va_gnt_ovc = {4{2'd1}};
        tick();
        va_gnt = '0; va_gnt_ovc = '0;
        #1;
        chk("R8 channel 2 requests switch", 32'(sa_req), 32'b0100);
        chk("R4 channel 0 still waiting", 32'(va_req), 32'b0001);
        send(4'b0100, "R8 channel 2 departs", 16'h0003, 2'd3, 2'd1, 2'd2);
        #1;
        chk("R7 channel 2 released sa_req", 32'(sa_req), 32'd0);
        chk("R7 channel 2 released va_req", 32'(va_req), 32'b0001);
        // R6: switch grant while still waiting moves nothing
        sa_gnt = 4'b0001; dn_credit = 4'b1111;
        #1;
        chk("R6 no departure while waiting", 32'(out_valid), 32'd0);
        tick();
        sa_gnt = '0; dn_credit = '0;
        va_gnt = 4'b0001; va_gnt_ovc = {4{2'd2}};
        tick();
        va_gnt = '0; va_gnt_ovc = '0;
        send(4'b0001, "R5 channel 0 departs", 16'h0001, 2'd1, 2'd2, 2'd0);
        #1;
        chk("R7 all idle", 32'({va_req, sa_req}), 32'd0);

        // R3: fresh packet on channel 0 is routed again; tail inherits
        put(2'd0, 2'b01, 16'h0002);
        tick();
        tick();
        #1;
        chk("R3 re-routed head port", 32'(va_port[1:0]), 32'd2);
        put(2'd0, 2'b10, 16'h0003);
        #1;
        chk("R3 port unchanged by later flit", 32'(va_port[1:0]), 32'd2);
        va_gnt = 4'b0001; va_gnt_ovc = {4{2'd0}};
        tick();
        va_gnt = '0; va_gnt_ovc = '0;
        send(4'b0001, "R3 head departs", 16'h0002, 2'd2, 2'd0, 2'd0);
        send(4'b0001, "R3 tail inherits", 16'h0003, 2'd2, 2'd0, 2'd0);

        // R2: fill channel 3 to depth, credit stall mid-drain
        put(2'd3, 2'b01, 16'h0040);
        put(2'd3, 2'b00, 16'h0041);
        put(2'd3, 2'b00, 16'h0042);
        put(2'd3, 2'b10, 16'h0043);
        #1;
        chk("R4 channel 3 waiting", 32'(va_req), 32'b1000);
        va_gnt = 4'b1000; va_gnt_ovc = {4{2'd3}};
        tick();
        va_gnt = '0; va_gnt_ovc = '0;
        send(4'b1000, "R2 burst flit 0", 16'h0040, 2'd0, 2'd3, 2'd3);
        sa_gnt = 4'b1000; dn_credit = 4'b0000;
        #1;
        chk("R6 no credit no departure", 32'(out_valid), 32'd0);
        tick();
        sa_gnt = '0;
        send(4'b1000, "R2 burst flit 1", 16'h0041, 2'd0, 2'd3, 2'd3);
        send(4'b1000, "R2 burst flit 2", 16'h0042, 2'd0, 2'd3, 2'd3);
        send(4'b1000, "R2 burst flit 3", 16'h0043, 2'd0, 2'd3, 2'd3);
        #1;
        chk("R7 channel 3 idle", 32'({va_req, sa_req}), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule